// File: doc/BRIEF.md
# Synchronous Flow-Through Burst Static RAM

This block is a synthesizable behavioural model of a synchronous static RAM word store with a built-in two-bit burst sequencer. The word is split into byte lanes (four lanes of nine bits by default, giving 36 bits). An access starts on a rising clock edge at which either of two address strobes is low. The external address is then captured, and a two-bit beat counter supplies the low address bits of the following beats. That counter steps only on edges where the advance input is low. A static order input selects linear stepping or interleaved stepping. Every burst wraps inside its aligned group of four words.

Reads are flow-through: once an edge has registered the address, the addressed word appears on the data output in that same clock period, with no output register. Writes take effect at the clock edge. Per-lane, common and global write inputs combine into one write enable per lane. The data bus is modelled as a separate output and a drive-enable flag; the bus counts as high-impedance whenever that flag is low. A sleep input freezes the block and tri-states the bus, and the stored words are kept.

Top module: `burst_sram`

## Requirements
- R1: During and right after reset, dq_en_o is 0 and the block is deselected.
- R2: A rising edge with chip_sel_n low and proc_strobe_n or ctrl_strobe_n low loads addr_i and clears the beat count. In the clock period after that edge, dq_o shows the stored word at addr_i (flow-through).
- R3: The beat count advances by one only on edges where advance_n is low, no strobe is low and the block is selected. On any other edge the read address holds.
- R4: With order_i = 0 (linear), beat n reads the address whose upper bits match the start address and whose low two bits are (start + n) mod 4. The upper bits never change during a burst.
- R5: With order_i = 1 (interleaved), the low two bits of beat n are start XOR n.
- R6: Lane i occupies dq bits [9i+8 : 9i]. Lane i is written at the edge's address when write_n and byte_wr_n[i] are both low. The other lanes keep their contents.
- R7: When global_wr_n is low, every lane is written, whatever write_n and byte_wr_n are.
- R8: On an edge where proc_strobe_n is low, all write inputs are ignored.
- R9: A strobe edge with chip_sel_n high deselects the block. dq_en_o is 0 from the next clock period on. Later advance and write inputs have no effect until a new selecting strobe.
- R10: dq_en_o is 0 whenever oe_n is high (combinational). It is also 0 in the clock period after any edge that wrote.
- R11: While sleep_i is high, dq_en_o is 0 at once and clock edges change neither the state nor the memory. Normal operation continues from the first edge after sleep_i falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr_i | input | ADDR_W | External word address |
| proc_strobe_n | input | 1 | Processor-side address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller-side address strobe, active low |
| chip_sel_n | input | 1 | Chip select sampled on strobe edges, active low |
| advance_n | input | 1 | Burst advance, active low |
| order_i | input | 1 | Static burst order: 0 linear, 1 interleaved |
| write_n | input | 1 | Common write enable, active low |
| global_wr_n | input | 1 | Global write of all lanes, active low |
| byte_wr_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, asynchronous, active low |
| sleep_i | input | 1 | Sleep, active high |
| dq_i | input | LANES*LANE_W | Write data |
| dq_o | output | LANES*LANE_W | Flow-through read data |
| dq_en_o | output | 1 | Bus drive enable; 0 means high-impedance |

## Verification
The sharpest overlap is a write that lands on the same edge as a burst step or a controller-strobe load: the word is stored at the address that the edge selects, and that word is read back on a later beat. Random runs keep advance, strobes, lane writes and global writes active together on the same edges. Short random sleep pulses fall in the middle of bursts. A bench reference model tracks the address, the select state and the stored words. It judges every cycle's drive enable and, while the bus is driven, the read word.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  // Low two address bits of beat `count` in a burst that starts at `start`.
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] count,
                                          input logic       interleave);
    logic [1:0] r;
    if (interleave) r = start ^ count;
    else            r = start + count;
    return r;
  endfunction

  // Write enable of a single lane from the three active-low write inputs.
  function automatic logic lane_write(input logic global_n,
                                      input logic common_n,
                                      input logic byte_n);
    return (!global_n) || (!common_n && !byte_n);
  endfunction

endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              start,
  input  logic              chip_en,
  input  logic              adv,
  input  logic              order,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              sel_q,
  output logic              sel_next,
  output logic [1:0]        cnt_q,
  output logic              step,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] wr_addr
);
  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        cnt_d;

  assign step = !hold && !start && adv && sel_q;

  always_comb begin
    base_d   = base_q;
    cnt_d    = cnt_q;
    sel_next = sel_q;
    if (start) begin
      base_d   = addr_in;
      cnt_d    = 2'd0;
      sel_next = chip_en;
    end else if (adv && sel_q) begin
      cnt_d = cnt_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= 2'd0;
      sel_q  <= 1'b0;
    end else if (!hold) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
      sel_q  <= sel_next;
    end
  end

  assign rd_addr = {base_q[ADDR_W-1:2], beat_low(base_q[1:0], cnt_q, order)};
  assign wr_addr = {base_d[ADDR_W-1:2], beat_low(base_d[1:0], cnt_d, order)};
endmodule

// File: rtl/byte_write_decode.sv
module byte_write_decode
  import burst_sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             global_n,
  input  logic             common_n,
  input  logic [LANES-1:0] byte_n,
  output logic [LANES-1:0] lane_we
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_we[l] = lane_write(global_n, common_n, byte_n[l]);
  end
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[l]) mem[waddr] <= wdata[l*LANE_W +: LANE_W];
    end
    assign rdata[l*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              proc_strobe_n,
  input  logic              ctrl_strobe_n,
  input  logic              chip_sel_n,
  input  logic              advance_n,
  input  logic              order_i,
  input  logic              write_n,
  input  logic              global_wr_n,
  input  logic [LANES-1:0]  byte_wr_n,
  input  logic              oe_n,
  input  logic              sleep_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_en_o
);
  // Named internal events, also used by the bound checker.
  logic              start;
  logic              step;
  logic              sel_q;
  logic              sel_next;
  logic [1:0]        cnt_q;
  logic [ADDR_W-1:0] rd_addr;
  logic [ADDR_W-1:0] wr_addr;
  logic [LANES-1:0]  lane_we;
  logic [LANES-1:0]  lane_commit;
  logic              write_commit;
  logic              wr_q;

  assign start = !proc_strobe_n || !ctrl_strobe_n;

  burst_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (sleep_i),
    .start    (start),
    .chip_en  (!chip_sel_n),
    .adv      (!advance_n),
    .order    (order_i),
    .addr_in  (addr_i),
    .sel_q    (sel_q),
    .sel_next (sel_next),
    .cnt_q    (cnt_q),
    .step     (step),
    .rd_addr  (rd_addr),
    .wr_addr  (wr_addr)
  );

  byte_write_decode #(.LANES(LANES)) u_wdec (
    .global_n (global_wr_n),
    .common_n (write_n),
    .byte_n   (byte_wr_n),
    .lane_we  (lane_we)
  );

  // A write lands only when the block is awake, selected after this edge,
  // and the processor strobe is not low on this edge.
  assign lane_commit  = (!sleep_i && sel_next && proc_strobe_n) ? lane_we : '0;
  assign write_commit = |lane_commit;

  sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk   (clk),
    .we    (lane_commit),
    .waddr (wr_addr),
    .wdata (dq_i),
    .raddr (rd_addr),
    .rdata (dq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wr_q <= 1'b0;
    else if (!sleep_i) wr_q <= write_commit;
  end

  assign dq_en_o = sel_q && !oe_n && !wr_q && !sleep_i;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep_i,
  input logic              oe_n,
  input logic              chip_sel_n,
  input logic              advance_n,
  input logic              start,
  input logic              step,
  input logic              write_commit,
  input logic              sel_q,
  input logic [1:0]        cnt_q,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              dq_en_o
);
  // R9: a strobe edge without chip select turns the bus off next cycle
  a_r9_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (start && chip_sel_n && !sleep_i) |=> !dq_en_o);

  // R10: output enable high keeps the bus off
  a_r10_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_en_o);

  // R10: the cycle after a write edge is never driven
  a_r10_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    write_commit |=> !dq_en_o);

  // R11: sleep tri-states the bus and freezes selection
  a_r11_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |-> !dq_en_o);
  a_r11_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> $stable(sel_q) && $stable(cnt_q));

  // R3: without advance or strobe the beat count holds
  a_r3_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && advance_n) |=> $stable(cnt_q));

  // R4: a burst step stays inside its aligned group of four
  a_r4_wrap_group: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> rd_addr[ADDR_W-1:2] == $past(rd_addr[ADDR_W-1:2]));

  // R1: no drive while in reset
  always_comb begin
    if (!rst_n) a_r1_reset_quiet: assert (!dq_en_o);
  end
endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sleep_i      (sleep_i),
  .oe_n         (oe_n),
  .chip_sel_n   (chip_sel_n),
  .advance_n    (advance_n),
  .start        (start),
  .step         (step),
  .write_commit (write_commit),
  .sel_q        (sel_q),
  .cnt_q        (cnt_q),
  .rd_addr      (rd_addr),
  .dq_en_o      (dq_en_o)
);

// File: tb/burst_sram_tb.sv
`timescale 1ns/1ps
module burst_sram_tb;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_i;
  logic          proc_strobe_n, ctrl_strobe_n, chip_sel_n, advance_n, order_i;
  logic          write_n, global_wr_n, oe_n, sleep_i;
  logic [NL-1:0] byte_wr_n;
  logic [DW-1:0] dq_i, dq_o;
  logic          dq_en_o;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  // reference model state
  logic [DW-1:0] ref_mem [DEPTH];
  bit            m_sel;
  logic [AW-1:0] m_base;
  int            m_cnt;
  bit            m_wrq;

  always #5 clk = ~clk;

  burst_sram u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
    .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
    .chip_sel_n(chip_sel_n), .advance_n(advance_n), .order_i(order_i),
    .write_n(write_n), .global_wr_n(global_wr_n), .byte_wr_n(byte_wr_n),
    .oe_n(oe_n), .sleep_i(sleep_i), .dq_i(dq_i), .dq_o(dq_o), .dq_en_o(dq_en_o)
  );

  function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] base, int n, bit inter);
    int lo, off;
    lo = int'(base) % 4;
    if (inter) off = lo ^ (n % 4);
    else       off = (lo + n) % 4;
    return AW'(int'(base) - lo + off);
  endfunction

  function automatic logic [DW-1:0] pattern(int a);
    return DW'(36'h5_A5A5_0000) ^ DW'(a * 32'h0001_0307);
  endfunction

  task automatic check_bit(string tag, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s dq_en_o actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_word(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s dq_o actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    proc_strobe_n = 1; ctrl_strobe_n = 1; chip_sel_n = 0; advance_n = 1;
    write_n = 1; global_wr_n = 1; byte_wr_n = '1; oe_n = 0; sleep_i = 0;
    addr_i = '0; dq_i = '0;
  endtask

  task automatic model_edge();
    bit st, wr;
    logic [AW-1:0] a;
    if (sleep_i) return;
    st = !proc_strobe_n || !ctrl_strobe_n;
    if (st) begin
      m_sel = !chip_sel_n; m_base = addr_i; m_cnt = 0;
    end else if (!advance_n && m_sel) begin
      m_cnt = (m_cnt + 1) % 4;
    end
    wr = 0;
    a = beat_addr(m_base, m_cnt, order_i);
    if (m_sel && proc_strobe_n) begin
      for (int l = 0; l < NL; l++) begin
        if (!global_wr_n || (!write_n && !byte_wr_n[l])) begin
          ref_mem[a][l*LW +: LW] = dq_i[l*LW +: LW];
          wr = 1;
        end
      end
    end
    m_wrq = wr;
  endtask

  // one clock: inputs were set before the call (at a falling edge)
  task automatic step(string tag);
    bit en;
    @(posedge clk);
    model_edge();
    #2;
    en = m_sel && !oe_n && !m_wrq && !sleep_i;
    check_bit(tag, dq_en_o, en);
    if (en) check_word(tag, dq_o, ref_mem[beat_addr(m_base, m_cnt, order_i)]);
    @(negedge clk);
  endtask

  task automatic start_burst(bit ctrl, logic [AW-1:0] a, string tag);
    idle(); addr_i = a;
    if (ctrl) ctrl_strobe_n = 0; else proc_strobe_n = 0;
    step(tag);
    idle();
  endtask

  initial begin
    void'($urandom(32'd20250611));
    idle(); order_i = 0;
    m_sel = 0; m_base = '0; m_cnt = 0; m_wrq = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check_bit("R1", dq_en_o, 1'b0);
    rst_n = 1;
    step("R1");

    // fill memory with controller-strobe global writes
    for (int a = 0; a < DEPTH; a++) begin
      idle(); ctrl_strobe_n = 0; addr_i = AW'(a); global_wr_n = 0; dq_i = pattern(a);
      step("R7");
    end
    idle(); step("R10");

    // R2: flow-through after either strobe
    start_burst(1, 6'd13, "R2");
    start_burst(0, 6'd22, "R2");

    // R4: linear burst 9,10,11,8,9
    order_i = 0;
    start_burst(1, 6'd9, "R4");
    for (int i = 0; i < 4; i++) begin advance_n = 0; step("R4"); end
    // R3: hold without advance
    idle(); step("R3"); step("R3");

    // R5: interleaved burst 9,8,11,10
    order_i = 1;
    start_burst(0, 6'd9, "R5");
    for (int i = 0; i < 4; i++) begin advance_n = 0; step("R5"); end
    idle(); order_i = 0;

    // R6: lane 1 only, with common write on the controller strobe edge
    idle(); ctrl_strobe_n = 0; addr_i = 6'd20; write_n = 0; byte_wr_n = 4'b1101;
    dq_i = '1; step("R6");
    start_burst(1, 6'd20, "R6");
    // write_n high: byte enables alone do nothing
    idle(); byte_wr_n = '0; dq_i = '0; step("R6");
    start_burst(1, 6'd20, "R6");

    // R7: global write overrides byte lanes
    idle(); ctrl_strobe_n = 0; addr_i = 6'd30; global_wr_n = 0; dq_i = 36'h1_2345_6789;
    step("R7");
    start_burst(1, 6'd30, "R7");

    // R8: writes ignored on a processor strobe edge
    idle(); proc_strobe_n = 0; addr_i = 6'd31; global_wr_n = 0; dq_i = '0;
    step("R8");
    idle(); step("R8");

    // R9: deselect, then advance and write have no effect
    idle(); ctrl_strobe_n = 0; chip_sel_n = 1; addr_i = 6'd40; step("R9");
    idle(); advance_n = 0; global_wr_n = 0; dq_i = '0; step("R9"); step("R9");
    start_burst(1, 6'd40, "R9");
    start_burst(1, 6'd41, "R9");

    // R10: output enable and write-turnaround
    start_burst(1, 6'd5, "R10");
    oe_n = 1; step("R10");
    oe_n = 0; step("R10");
    global_wr_n = 0; dq_i = 36'h0_0F0F_F0F0; step("R10");
    idle(); step("R10");

    // R11: sleep ignores strobe and write, keeps contents
    start_burst(1, 6'd50, "R11");
    sleep_i = 1; ctrl_strobe_n = 0; addr_i = 6'd51; global_wr_n = 0; dq_i = '0;
    step("R11"); step("R11");
    idle(); step("R11");
    start_burst(1, 6'd51, "R11");

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0) order_i = $urandom % 2;
      proc_strobe_n = ($urandom % 8) != 0;
      ctrl_strobe_n = ($urandom % 6) != 0;
      chip_sel_n    = ($urandom % 8) == 0;
      addr_i        = AW'($urandom);
      advance_n     = $urandom % 2;
      write_n       = ($urandom % 3) != 0;
      global_wr_n   = ($urandom % 10) != 0;
      byte_wr_n     = NL'($urandom);
      oe_n          = ($urandom % 10) == 0;
      sleep_i       = ($urandom % 25) == 0;
      dq_i          = DW'({$urandom, $urandom});
      step("R2");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule